// File: doc/BRIEF.md
# SPI flash command sequencer

This block drives a serial flash device over a single-lane SPI link (clock, chip select, one data line each way). Software starts an operation by setting one bit in the upper half of a 32-bit command register. Each of the sixteen bits stands for one fixed flash operation, with its own opcode and frame layout. The sequencer lowers chip select and shifts out the opcode. Depending on the operation, it then sends a 24-bit address, dummy bytes, or data bytes taken from a write buffer, and it captures any returned bytes into a read buffer. When the frame is done it releases chip select and clears the trigger bit.

The host port works like a register file. Writes take one cycle and are never stalled. Reads are combinational from `host_raddr`. Because the port never stalls, the only back-pressure is the `busy` flag: while `busy` is 1, every host write is dropped, so software must poll `busy` (or the status register) before it issues the next write. The SPI clock runs in mode 0. It idles low, the device samples `spi_mosi` on the rising edge, bytes go most significant bit first, and `spi_miso` is sampled on the rising edge as well. Each SPI clock phase lasts `HALF_DIV` system clocks.

Host map (9-bit addresses):
- 0x000 command: bits 31..16 are the triggers; bits 15..0 read as 0.
- 0x001 flash address, bits 23..0.
- 0x002 user opcode, bits 7..0.
- 0x003 lengths: bits 7..0 hold the page-program byte count minus one, and bits 13..8 hold the read byte count minus one.
- 0x004 status: bit 0 is busy.
- 0x080..0x0BF: read buffer bytes 0..63 (read only).
- 0x100..0x1FF: write buffer bytes 0..255 (write only, data in bits 7..0).

Top module: `spi_flash_cmd_seq`

## Requirements
- R1: After reset, `busy` is 0, `spi_cs_n` is 1, `spi_sclk` is 0, and both the command register and the status register read 0.
- R2: Each trigger bit sends its own first byte. Bit 16 sends 0x7A, 17 sends 0x75, 19 sends 0xA3, 21 sends 0xB9, 22 sends 0xC7, 23 sends 0xD8, 24 sends 0x20, 25 sends 0x02, 26 sends 0x01, 27 sends 0x05, 28 sends 0x9F, 29 sends 0x04, 30 sends 0x06 and 31 sends 0x03. A bit with no address, data or read phase produces a 1-byte frame.
- R3: Bits 31, 25, 24 and 23 send the 24-bit flash address right after the opcode, in three bytes with the most significant byte first.
- R4: Bit 25 sends (length bits 7..0)+1 data bytes, from 1 to 256, taken from write buffer entries 0 upward. Bit 26 sends exactly one data byte, write buffer entry 0.
- R5: Bit 31 clocks in (length bits 13..8)+1 bytes, from 1 to 64, after the address. Bit 28 clocks in 3 bytes after the opcode, and bit 27 clocks in 1 byte. The k-th received byte is readable at 0x080+k.
- R6: Bit 20 sends three 0x00 dummy bytes after the opcode 0xAB, then clocks in one byte, which is readable at 0x080.
- R7: Bit 18 sends a 1-byte frame whose byte is the value of the user-opcode register.
- R8: When one write sets several trigger bits, only the highest-numbered bit runs (exactly one frame), and the other bits are discarded.
- R9: From the write that starts an operation until its frame ends, `busy` and status bit 0 read 1, and the command register reads back the single bit being serviced. Afterwards all of them read 0.
- R10: Every host write made while `busy` is 1 is ignored. No new frame starts, and no register changes.
- R11: SPI mode 0 framing is kept. `spi_sclk` stays low while `spi_cs_n` is high, `spi_mosi` is stable at every rising edge, and a frame holds exactly 8 rising edges per byte.
- R12: A write to the command register that sets no bit in 31..16 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe, accepted when `busy` is 0 |
| host_waddr | input | 9 | Host write address |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | 9 | Host read address |
| host_rdata | output | 32 | Host read data, combinational |
| busy | output | 1 | An operation is in progress |
| spi_sclk | output | 1 | SPI serial clock, idles low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench provokes two events that share a single host write cycle. In the first, a write sets two trigger bits at once (22 and 21). The bench judges it by the one frame that follows, whose first byte is 0xC7, and by the command read-back, which shows only bit 22 while the frame runs. In the second, a new trigger write and an address-register write arrive while a read frame is still shifting. The bench judges these by counting chip-select frames after the sequencer goes idle and by reading back the unchanged address. A bus model of the flash, driven by the SPI pins, records every byte and answers with a pattern the bench computes by itself.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  localparam int TRIG_COUNT = 16;
  localparam int TRIG_LSB   = 16;

  typedef enum logic [1:0] {WR_NONE, WR_ONE, WR_PAGE} wr_kind_e;
  typedef enum logic [1:0] {RD_NONE, RD_ONE, RD_THREE, RD_LEN} rd_kind_e;

  typedef struct packed {
    logic [7:0] opcode;
    logic       use_uop;
    logic       has_addr;
    logic       dummy3;
    wr_kind_e   wr;
    rd_kind_e   rd;
  } op_desc_t;

  // k is the trigger bit number minus TRIG_LSB
  function automatic op_desc_t desc_for(input logic [3:0] k);
    op_desc_t d;
    d = '{opcode: 8'h00, use_uop: 1'b0, has_addr: 1'b0, dummy3: 1'b0,
          wr: WR_NONE, rd: RD_NONE};
    case (k)
      4'd15: begin d.opcode = 8'h03; d.has_addr = 1'b1; d.rd = RD_LEN; end
      4'd14: d.opcode = 8'h06;
      4'd13: d.opcode = 8'h04;
      4'd12: begin d.opcode = 8'h9F; d.rd = RD_THREE; end
      4'd11: begin d.opcode = 8'h05; d.rd = RD_ONE; end
      4'd10: begin d.opcode = 8'h01; d.wr = WR_ONE; end
      4'd9:  begin d.opcode = 8'h02; d.has_addr = 1'b1; d.wr = WR_PAGE; end
      4'd8:  begin d.opcode = 8'h20; d.has_addr = 1'b1; end
      4'd7:  begin d.opcode = 8'hD8; d.has_addr = 1'b1; end
      4'd6:  d.opcode = 8'hC7;
      4'd5:  d.opcode = 8'hB9;
      4'd4:  begin d.opcode = 8'hAB; d.dummy3 = 1'b1; d.rd = RD_ONE; end
      4'd3:  d.opcode = 8'hA3;
      4'd2:  d.use_uop = 1'b1;
      4'd1:  d.opcode = 8'h75;
      default: d.opcode = 8'h7A;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/spi_seq_decode.sv
module spi_seq_decode
  import spi_seq_pkg::*;
#(
  parameter int NTRIG = TRIG_COUNT
) (
  input  logic [NTRIG-1:0] trig,
  output logic [NTRIG-1:0] pick,
  output logic             any,
  output op_desc_t         desc
);
  localparam int SEL_W = $clog2(NTRIG);

  logic [SEL_W-1:0] sel;

  // ascending scan: the highest set bit is the last to win
  always_comb begin
    pick = '0;
    any  = 1'b0;
    sel  = '0;
    for (int i = 0; i < NTRIG; i++) begin
      if (trig[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
        sel     = SEL_W'(i);
        any     = 1'b1;
      end
    end
    desc = desc_for(4'(sel));
  end

endmodule

// File: rtl/spi_seq_shifter.sv
module spi_seq_shifter #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int DIV_W = $clog2(HALF_DIV) + 1;

  logic             active;
  logic [DIV_W-1:0] div_cnt;
  logic [2:0]       bit_cnt;
  logic [7:0]       tx_sh;
  logic [7:0]       rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      sclk    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active  <= 1'b1;
        tx_sh   <= tx_byte;
        bit_cnt <= '0;
        div_cnt <= '0;
        sclk    <= 1'b0;
      end else if (active) begin
        if (div_cnt == DIV_W'(HALF_DIV - 1)) begin
          div_cnt <= '0;
          if (!sclk) begin
            sclk  <= 1'b1;
            rx_sh <= {rx_sh[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bit_cnt == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
              tx_sh   <= {tx_sh[6:0], 1'b0};
            end
          end
        end else begin
          div_cnt <= div_cnt + DIV_W'(1);
        end
      end
    end
  end

  assign mosi    = tx_sh[7];
  assign rx_byte = rx_sh;

  AST_MOSI_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi)); // R11
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active); // R11

endmodule

// File: rtl/spi_flash_cmd_seq.sv
module spi_flash_cmd_seq
  import spi_seq_pkg::*;
#(
  parameter int HALF_DIV    = 2,
  parameter int WBUF_DEPTH  = 256,
  parameter int RBUF_DEPTH  = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [8:0]  host_waddr,
  input  logic [31:0] host_wdata,
  input  logic [8:0]  host_raddr,
  output logic [31:0] host_rdata,
  output logic        busy,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int WB_AW  = $clog2(WBUF_DEPTH);
  localparam int RB_AW  = $clog2(RBUF_DEPTH);
  localparam int CNT_W  = $clog2(WBUF_DEPTH + RBUF_DEPTH + 8) + 1;
  localparam int ADDR_W = 24;

  localparam logic [8:0] A_CMD  = 9'h000;
  localparam logic [8:0] A_ADDR = 9'h001;
  localparam logic [8:0] A_UOP  = 9'h002;
  localparam logic [8:0] A_LEN  = 9'h003;
  localparam logic [8:0] A_STAT = 9'h004;
  localparam logic [2:0] RB_TAG = 3'b010;   // 0x080..0x0BF

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOAD, S_SHIFT, S_HOLD} st_e;

  st_e                   state;
  logic [TRIG_COUNT-1:0] trig_q;
  logic [ADDR_W-1:0]     addr_q;
  logic [7:0]            uop_q;
  logic [WB_AW-1:0]      pp_len_m1;
  logic [RB_AW-1:0]      rd_len_m1;
  logic [7:0]            op_q;
  logic [CNT_W-1:0]      idx, addr_end_q, wr_start_q, rd_start_q, last_q;
  logic [7:0]            wbuf [WBUF_DEPTH];
  logic [7:0]            rbuf [RBUF_DEPTH];

  logic                  wr_ok;
  logic                  cmd_wr;
  logic [TRIG_COUNT-1:0] dec_pick;
  logic                  dec_any;
  op_desc_t              dec_desc;
  logic [CNT_W-1:0]      n_addr, n_dum, n_wr, n_rd;
  logic [7:0]            tx_byte;
  logic                  sh_start, sh_done;
  logic [7:0]            sh_rx;
  logic [WB_AW-1:0]      wr_off;
  logic [RB_AW-1:0]      rd_off;

  assign busy   = (state != S_IDLE);
  assign wr_ok  = host_we && !busy;
  assign cmd_wr = wr_ok && (host_waddr == A_CMD);

  spi_seq_decode #(.NTRIG(TRIG_COUNT)) u_decode (
    .trig (host_wdata[TRIG_LSB +: TRIG_COUNT]),
    .pick (dec_pick),
    .any  (dec_any),
    .desc (dec_desc)
  );

  // frame geometry of the requested operation
  always_comb begin
    n_addr = dec_desc.has_addr ? CNT_W'(3) : '0;
    n_dum  = dec_desc.dummy3   ? CNT_W'(3) : '0;
    case (dec_desc.wr)
      WR_ONE:  n_wr = CNT_W'(1);
      WR_PAGE: n_wr = CNT_W'(pp_len_m1) + CNT_W'(1);
      default: n_wr = '0;
    endcase
    case (dec_desc.rd)
      RD_ONE:   n_rd = CNT_W'(1);
      RD_THREE: n_rd = CNT_W'(3);
      RD_LEN:   n_rd = CNT_W'(rd_len_m1) + CNT_W'(1);
      default:  n_rd = '0;
    endcase
  end

  // host configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      uop_q     <= '0;
      pp_len_m1 <= '0;
      rd_len_m1 <= '0;
    end else if (wr_ok) begin
      case (host_waddr)
        A_ADDR: addr_q <= host_wdata[ADDR_W-1:0];
        A_UOP:  uop_q  <= host_wdata[7:0];
        A_LEN: begin
          pp_len_m1 <= host_wdata[WB_AW-1:0];
          rd_len_m1 <= host_wdata[8 +: RB_AW];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok && host_waddr[8])
      wbuf[host_waddr[WB_AW-1:0]] <= host_wdata[7:0];
  end

  // frame sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      trig_q     <= '0;
      op_q       <= '0;
      idx        <= '0;
      addr_end_q <= '0;
      wr_start_q <= '0;
      rd_start_q <= '0;
      last_q     <= '0;
      spi_cs_n   <= 1'b1;
    end else begin
      case (state)
        S_IDLE: begin
          if (cmd_wr && dec_any) begin
            trig_q     <= dec_pick;
            op_q       <= dec_desc.use_uop ? uop_q : dec_desc.opcode;
            idx        <= '0;
            addr_end_q <= CNT_W'(1) + n_addr;
            wr_start_q <= CNT_W'(1) + n_addr + n_dum;
            rd_start_q <= CNT_W'(1) + n_addr + n_dum + n_wr;
            last_q     <= n_addr + n_dum + n_wr + n_rd;
            spi_cs_n   <= 1'b0;
            state      <= S_SETUP;
          end
        end
        S_SETUP: state <= S_LOAD;
        S_LOAD:  state <= S_SHIFT;
        S_SHIFT: begin
          if (sh_done) begin
            if (idx == last_q) begin
              state <= S_HOLD;
            end else begin
              idx   <= idx + CNT_W'(1);
              state <= S_LOAD;
            end
          end
        end
        default: begin
          spi_cs_n <= 1'b1;
          trig_q   <= '0;
          state    <= S_IDLE;
        end
      endcase
    end
  end

  assign wr_off = WB_AW'(idx - wr_start_q);
  assign rd_off = RB_AW'(idx - rd_start_q);

  always_ff @(posedge clk) begin
    if (state == S_SHIFT && sh_done && idx >= rd_start_q)
      rbuf[rd_off] <= sh_rx;
  end

  // byte to send at frame position idx
  always_comb begin
    tx_byte = 8'h00;
    if (idx == '0) begin
      tx_byte = op_q;
    end else if (idx < addr_end_q) begin
      case (idx[1:0])
        2'd1:    tx_byte = addr_q[23:16];
        2'd2:    tx_byte = addr_q[15:8];
        default: tx_byte = addr_q[7:0];
      endcase
    end else if (idx >= wr_start_q && idx < rd_start_q) begin
      tx_byte = wbuf[wr_off];
    end
  end

  assign sh_start = (state == S_LOAD);

  spi_seq_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (sh_start),
    .tx_byte (tx_byte),
    .miso    (spi_miso),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .done    (sh_done),
    .rx_byte (sh_rx)
  );

  // host read mux
  always_comb begin
    host_rdata = '0;
    if (host_raddr[8:6] == RB_TAG) begin
      host_rdata[7:0] = rbuf[host_raddr[RB_AW-1:0]];
    end else begin
      case (host_raddr)
        A_CMD:  host_rdata[TRIG_LSB +: TRIG_COUNT] = trig_q;
        A_ADDR: host_rdata[ADDR_W-1:0] = addr_q;
        A_UOP:  host_rdata[7:0] = uop_q;
        A_LEN: begin
          host_rdata[WB_AW-1:0]  = pp_len_m1;
          host_rdata[8 +: RB_AW] = rd_len_m1;
        end
        A_STAT: host_rdata[0] = busy;
        default: ;
      endcase
    end
  end

  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R11
  AST_ONE_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trig_q)); // R8
  AST_BUSY_TRACKS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (trig_q != '0)); // R9
  AST_TRIG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state != S_HOLD) |=> $stable(trig_q)); // R10
  AST_CLEAR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> (trig_q == '0)); // R9

endmodule

// File: tb/spi_flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module spi_flash_cmd_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [8:0]  host_waddr = '0;
  logic [31:0] host_wdata = '0;
  logic [8:0]  host_raddr = '0;
  logic [31:0] host_rdata;
  logic        busy, spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  always #2.5 clk = ~clk;

  spi_flash_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
    .busy(busy), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_chk = 0;
  int n_fail = 0;

  // ---------------- flash bus model ----------------
  logic [7:0] cap [300];
  logic [7:0] sh = '0;
  int bc = 0;
  int frames = 0;
  int idle_edges = 0;
  logic [7:0] cur_resp;

  function automatic logic [7:0] resp(input int p);
    return 8'hC3 ^ 8'(p * 37);
  endfunction

  function automatic logic [7:0] wexp(input int i);
    return 8'(8'h10 + i * 7);
  endfunction

  always @(negedge spi_cs_n) begin
    bc = 0;
    frames++;
  end

  always @(posedge spi_sclk) begin
    if (spi_cs_n) idle_edges++;
    else begin
      sh = {sh[6:0], spi_mosi};
      if ((bc % 8) == 7 && bc / 8 < 300) cap[bc / 8] = sh;
      bc++;
    end
  end

  always_comb cur_resp = resp(bc / 8);
  assign spi_miso = cur_resp[7 - (bc % 8)];

  // ---------------- helpers ----------------
  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic hwr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_waddr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hrd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    host_raddr = a;
    #1 d = host_rdata;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // {bit, opcode, has_addr, rd_n, rd_off, total}
  localparam logic [31:0] VEC [16] = '{
    32'h1F03_1549, 32'h1E06_0001, 32'h1D04_0001, 32'h1C9F_0314,
    32'h1B05_0112, 32'h1A01_0002, 32'h1902_1008, 32'h1820_1004,
    32'h17D8_1004, 32'h16C7_0001, 32'h15B9_0001, 32'h14AB_0145,
    32'h13A3_0001, 32'h125E_0001, 32'h1175_0001, 32'h107A_0001
  };

  localparam logic [23:0] FADDR = 24'h3A5C71;

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog: actual 0x%0h expected 0x%0h", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(spi_cs_n == 1'b1, "R1", "cs_n", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R1", "sclk", spi_sclk, 0);
    hrd(9'h000, rd); chk(rd == 0, "R1", "cmd", rd, 0);
    hrd(9'h004, rd); chk(rd == 0, "R1", "status", rd, 0);

    // R12 lower bits only
    f0 = frames;
    hwr(9'h000, 32'h0000_FFFF);
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && frames == f0, "R12", "frames", frames - f0, 0);

    // setup
    for (int i = 0; i < 256; i++) hwr(9'h100 + 9'(i), 32'(wexp(i)));
    hwr(9'h001, 32'(FADDR));
    hwr(9'h002, 32'h5E);
    hwr(9'h003, 32'h0403);

    // table walk: R2..R7
    for (int v = 0; v < 16; v++) begin
      int bitn, hasa, rdn, off, tot;
      logic [7:0] opc;
      bitn = int'(VEC[v][31:24]); opc = VEC[v][23:16];
      hasa = int'(VEC[v][15:12]); rdn = int'(VEC[v][11:8]);
      off  = int'(VEC[v][7:4]);   tot = int'(VEC[v][3:0]);
      f0 = frames;
      hwr(9'h000, 32'h1 << bitn);
      chk(busy == 1'b1, "R9", "busy during op", busy, 1);
      wait_idle();
      chk(frames == f0 + 1, "R2", "frame count", frames - f0, 1);
      chk(cap[0] == opc, (bitn == 18) ? "R7" : "R2", "opcode", cap[0], opc);
      chk(bc == tot * 8, "R11", "edge count", bc, tot * 8);
      if (hasa != 0) begin
        chk(cap[1] == FADDR[23:16], "R3", "addr hi", cap[1], FADDR[23:16]);
        chk(cap[2] == FADDR[15:8],  "R3", "addr mid", cap[2], FADDR[15:8]);
        chk(cap[3] == FADDR[7:0],   "R3", "addr lo", cap[3], FADDR[7:0]);
      end
      if (bitn == 25)
        for (int i = 0; i < 4; i++)
          chk(cap[4 + i] == wexp(i), "R4", "page data", cap[4 + i], wexp(i));
      if (bitn == 26)
        chk(cap[1] == wexp(0), "R4", "status write data", cap[1], wexp(0));
      if (bitn == 20)
        for (int i = 1; i < 4; i++)
          chk(cap[i] == 8'h00, "R6", "dummy byte", cap[i], 0);
      for (int i = 0; i < rdn; i++) begin
        hrd(9'h080 + 9'(i), rd);
        chk(rd[7:0] == resp(off + i), (bitn == 20) ? "R6" : "R5", "read byte",
            rd[7:0], resp(off + i));
      end
      hrd(9'h000, rd); chk(rd == 0, "R9", "cmd cleared", rd, 0);
      hrd(9'h004, rd); chk(rd == 0, "R9", "status cleared", rd, 0);
    end

    // R8 two triggers in one write
    f0 = frames;
    hwr(9'h000, 32'h0060_0000);
    hrd(9'h000, rd); chk(rd == 32'h0040_0000, "R8", "cmd readback", rd, 32'h0040_0000);
    wait_idle();
    chk(frames == f0 + 1, "R8", "frames", frames - f0, 1);
    chk(cap[0] == 8'hC7, "R8", "opcode", cap[0], 8'hC7);

    // R10 writes during busy
    f0 = frames;
    hwr(9'h000, 32'h8000_0000);
    hwr(9'h000, 32'h4000_0000);
    hwr(9'h001, 32'h0);
    wait_idle();
    repeat (40) @(negedge clk);
    chk(frames == f0 + 1, "R10", "frames", frames - f0, 1);
    hrd(9'h001, rd); chk(rd == 32'(FADDR), "R10", "addr kept", rd, 32'(FADDR));

    // R4 full page
    hwr(9'h003, 32'h04FF);
    hwr(9'h000, 32'h0200_0000);
    wait_idle();
    chk(bc == 260 * 8, "R4", "page edges", bc, 260 * 8);
    chk(cap[4] == wexp(0), "R4", "first page byte", cap[4], wexp(0));
    chk(cap[259] == wexp(255), "R4", "last page byte", cap[259], wexp(255));

    // R5 read 64 and read 1
    hwr(9'h003, 32'h3F03);
    hwr(9'h000, 32'h8000_0000);
    wait_idle();
    chk(bc == 68 * 8, "R5", "read64 edges", bc, 68 * 8);
    hrd(9'h080, rd); chk(rd[7:0] == resp(4), "R5", "read64 first", rd[7:0], resp(4));
    hrd(9'h0BF, rd); chk(rd[7:0] == resp(67), "R5", "read64 last", rd[7:0], resp(67));
    hwr(9'h003, 32'h0003);
    hwr(9'h000, 32'h8000_0000);
    wait_idle();
    chk(bc == 5 * 8, "R5", "read1 edges", bc, 5 * 8);
    hrd(9'h080, rd); chk(rd[7:0] == resp(4), "R5", "read1 byte", rd[7:0], resp(4));

    chk(idle_edges == 0, "R11", "sclk edges outside frame", idle_edges, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule